// File: doc/BRIEF.md
# Iterative Multiplier with High-Half Variants

This block multiplies two 32-bit operands over several clock cycles. A single 32-step pass builds two results at once. A left-shifting accumulator collects the low 32 bits of the product. A right-shifting accumulator collects the upper 32 bits of the unsigned product. After the loop, one correction cycle turns the unsigned upper half into the signed-by-unsigned or signed-by-signed upper half by subtracting the other operand where needed. No separate signed multiply is used.

The caller presents a primary opcode, an extended opcode, two 5-bit register fields, a 16-bit immediate and the two operand values, and pulses `start`. The primary opcode selects either the register-register form or the immediate form. In the register-register form the extended opcode picks the variant. In the immediate form the second operand is the sign-extended immediate. The block answers with a one-cycle `done` pulse. At that point it presents the 32-bit result and the index of the destination register, and it holds both until the next operation completes.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. Start while idle takes the transition *launch* into `ST_LOOP`.
- `ST_LOOP` runs one shift-and-add step per cycle. After the 32nd step it takes *finish_loop* into `ST_FIX`.
- `ST_FIX` applies the correction, registers the result and raises `done`. It then takes *retire* back to `ST_IDLE`.

Top module: `iter_mul`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `result` and `dest` are all 0.
- R2: A `start` seen while idle launches an operation and `busy` goes high on the next cycle. A `start` seen while busy is ignored: its operands, opcodes and fields do not affect the result that is returned.
- R3: `done` rises exactly 33 clock edges after the edge that accepted `start` (XLEN + 1). It stays high for exactly one cycle, and `busy` is low whenever `done` is high.
- R4: `result` and `dest` change only in the cycle in which `done` rises. Input changes without a start leave them unchanged.
- R5: Primary opcode 0x3a with extended opcode 0x27 returns the low 32 bits of src_a × src_b.
- R6: Primary opcode 0x3a with extended opcode 0x07 returns the upper 32 bits of the unsigned × unsigned product.
- R7: Primary opcode 0x3a with extended opcode 0x17 returns the upper 32 bits of signed src_a × unsigned src_b.
- R8: Primary opcode 0x3a with extended opcode 0x1f returns the upper 32 bits of signed src_a × signed src_b.
- R9: Primary opcode 0x24 (immediate form) returns the low 32 bits of src_a × sign-extended `imm16`. `src_b` and `ext_code` have no effect in this form.
- R10: `dest` is `fld_b` in the immediate form and `fld_c` in all other forms.
- R11: Any extended opcode other than 0x27, 0x07 and 0x17, and any primary opcode other than 0x24, is handled as the register form. Where the extended opcode is not one of those three, the operation is the signed × signed upper half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when idle |
| op_code | input | 6 | Primary opcode (0x24 immediate form, else register form) |
| ext_code | input | 6 | Extended opcode for the register form |
| fld_b | input | 5 | Register field B (destination in immediate form) |
| fld_c | input | 5 | Register field C (destination in register form) |
| imm16 | input | 16 | Immediate, sign-extended to form the second operand |
| src_a | input | 32 | First operand (multiplicand) |
| src_b | input | 32 | Second operand in the register form |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected product half |
| dest | output | 5 | Destination register index for the result |

## Verification
The bench drives operands whose sign bits sit at the edges: 0x80000000, 0xFFFFFFFF, zero, and negative immediates. Several failure modes show up on these inputs:
- A design that drops the carry out of the high accumulator gives a wrong unsigned upper half when both operands are large.
- A design that swaps or skips a correction term gives an upper half that is off by one operand value, but only when an operand is negative.
- A design that zero-extends the immediate fails on negative immediates.

The bench also pulses `start` again in the middle of an operation with other operands. A design that re-launches would return the wrong product or finish late. Each completion is timed to the exact edge, so an extra or missing loop step is caught even when the product happens to match.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOP,
        ST_FIX
    } mul_state_e;

    typedef enum logic [1:0] {
        SEL_LO,
        SEL_HUU,
        SEL_HSU,
        SEL_HSS
    } mul_sel_e;

    localparam logic [5:0] OPC_IMM  = 6'h24;
    localparam logic [5:0] OPC_REG  = 6'h3a;
    localparam logic [5:0] XOP_LO   = 6'h27;
    localparam logic [5:0] XOP_HUU  = 6'h07;
    localparam logic [5:0] XOP_HSU  = 6'h17;
    localparam logic [5:0] XOP_HSS  = 6'h1f;

endpackage

// File: rtl/mul_decode.sv
module mul_decode
    import mul_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [5:0]      op_code,
    input  logic [5:0]      ext_code,
    input  logic [4:0]      fld_b,
    input  logic [4:0]      fld_c,
    input  logic [15:0]     imm16,
    input  logic [XLEN-1:0] src_b,
    output mul_sel_e        sel,
    output logic [XLEN-1:0] oper2,
    output logic [4:0]      dst
);
    logic is_imm;

    assign is_imm = (op_code == OPC_IMM);

    always_comb begin
        if (is_imm) begin
            sel   = SEL_LO;
            oper2 = {{(XLEN-16){imm16[15]}}, imm16};
            dst   = fld_b;
        end else begin
            oper2 = src_b;
            dst   = fld_c;
            unique case (ext_code)
                XOP_LO:  sel = SEL_LO;
                XOP_HUU: sel = SEL_HUU;
                XOP_HSU: sel = SEL_HSU;
                default: sel = SEL_HSS;
            endcase
        end
    end
endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] mcand_in,
    input  logic [XLEN-1:0] mplr_in,
    output logic [XLEN-1:0] acc_lo,
    output logic [XLEN-1:0] acc_hi
);
    logic [XLEN-1:0] mcand;
    logic [XLEN-1:0] mplr_up;
    logic [XLEN-1:0] mplr_dn;
    logic [XLEN:0]   hi_sum;
    logic [XLEN-1:0] lo_next;

    assign hi_sum  = {1'b0, acc_hi} + (mplr_dn[0] ? {1'b0, mcand} : '0);
    assign lo_next = {acc_lo[XLEN-2:0], 1'b0} + (mplr_up[XLEN-1] ? mcand : '0);

    always_ff @(posedge clk) begin
        if (load) begin
            acc_lo  <= '0;
            acc_hi  <= '0;
            mcand   <= mcand_in;
            mplr_up <= mplr_in;
            mplr_dn <= mplr_in;
        end else if (step) begin
            acc_lo  <= lo_next;
            acc_hi  <= hi_sum[XLEN:1];
            mplr_up <= {mplr_up[XLEN-2:0], 1'b0};
            mplr_dn <= {1'b0, mplr_dn[XLEN-1:1]};
        end
    end
endmodule

// File: rtl/mul_fix.sv
module mul_fix
    import mul_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  mul_sel_e        sel,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] lo,
    input  logic [XLEN-1:0] hi_uu,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] hi_su;
    logic [XLEN-1:0] hi_ss;

    assign hi_su = hi_uu - (opa[XLEN-1] ? opb : '0);
    assign hi_ss = hi_su - (opb[XLEN-1] ? opa : '0);

    always_comb begin
        unique case (sel)
            SEL_LO:  res = lo;
            SEL_HUU: res = hi_uu;
            SEL_HSU: res = hi_su;
            default: res = hi_ss;
        endcase
    end
endmodule

// File: rtl/iter_mul.sv
module iter_mul
    import mul_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [5:0]      op_code,
    input  logic [5:0]      ext_code,
    input  logic [4:0]      fld_b,
    input  logic [4:0]      fld_c,
    input  logic [15:0]     imm16,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [4:0]      dest
);
    localparam int CNT_W = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(XLEN - 1);

    mul_state_e      state, state_nx;
    logic [CNT_W-1:0] step_cnt;
    mul_sel_e        dec_sel, sel_q;
    logic [XLEN-1:0] dec_op2, opa_q, opb_q;
    logic [4:0]      dec_dst, dst_q;
    logic [XLEN-1:0] acc_lo, acc_hi, fix_res;
    logic            launch;

    assign launch = (state == ST_IDLE) && start;
    assign busy   = (state != ST_IDLE);

    mul_decode #(.XLEN(XLEN)) u_dec (
        .op_code  (op_code),
        .ext_code (ext_code),
        .fld_b    (fld_b),
        .fld_c    (fld_c),
        .imm16    (imm16),
        .src_b    (src_b),
        .sel      (dec_sel),
        .oper2    (dec_op2),
        .dst      (dec_dst)
    );

    mul_core #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .load     (launch),
        .step     (state == ST_LOOP),
        .mcand_in (src_a),
        .mplr_in  (dec_op2),
        .acc_lo   (acc_lo),
        .acc_hi   (acc_hi)
    );

    mul_fix #(.XLEN(XLEN)) u_fix (
        .sel   (sel_q),
        .opa   (opa_q),
        .opb   (opb_q),
        .lo    (acc_lo),
        .hi_uu (acc_hi),
        .res   (fix_res)
    );

    // next state: launch, finish_loop, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOOP;
            ST_LOOP: if (step_cnt == LAST_STEP) state_nx = ST_FIX;
            ST_FIX:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operation capture and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            sel_q    <= SEL_LO;
            opa_q    <= '0;
            opb_q    <= '0;
            dst_q    <= '0;
        end else if (launch) begin
            step_cnt <= '0;
            sel_q    <= dec_sel;
            opa_q    <= src_a;
            opb_q    <= dec_op2;
            dst_q    <= dec_dst;
        end else if (state == ST_LOOP) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            dest   <= '0;
        end else begin
            done <= (state == ST_FIX);
            if (state == ST_FIX) begin
                result <= fix_res;
                dest   <= dst_q;
            end
        end
    end
endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic [4:0]      dest
);
    int unsigned busy_cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)              busy_cyc <= 0;
        else if (start && !busy) busy_cyc <= 0;
        else if (busy)           busy_cyc <= busy_cyc + 1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0 && dest == '0));

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (busy_cyc == XLEN + 1));

    a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(result) && $stable(dest))));
endmodule

bind iter_mul iter_mul_chk #(.XLEN(XLEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .dest   (dest)
);

// File: tb/iter_mul_test.sv
`timescale 1ns/1ps
module iter_mul_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  op_code = '0;
    logic [5:0]  ext_code = '0;
    logic [4:0]  fld_b = '0;
    logic [4:0]  fld_c = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy, done;
    logic [31:0] result;
    logic [4:0]  dest;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    iter_mul uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .ext_code(ext_code), .fld_b(fld_b), .fld_c(fld_c), .imm16(imm16),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .result(result), .dest(dest)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic [5:0] opc, logic [5:0] xop,
                                          logic [15:0] imm, logic [31:0] a,
                                          logic [31:0] b);
        logic [63:0] ea, eb, p;
        if (opc == 6'h24) begin
            p = {{32{a[31]}}, a} * {{48{imm[15]}}, imm};
            return p[31:0];
        end
        ea = {{32{a[31]}}, a};
        eb = {{32{b[31]}}, b};
        case (xop)
            6'h27: begin p = ea * eb; return p[31:0]; end
            6'h07: begin p = {32'b0, a} * {32'b0, b}; return p[63:32]; end
            6'h17: begin p = ea * {32'b0, b}; return p[63:32]; end
            default: begin p = ea * eb; return p[63:32]; end
        endcase
    endfunction

    // Launch one operation; optionally pulse a disturbing start mid-run.
    task automatic run_op(string req, logic [5:0] opc, logic [5:0] xop,
                          logic [4:0] fb, logic [4:0] fc, logic [15:0] imm,
                          logic [31:0] a, logic [31:0] b, bit disturb);
        int n;
        logic [31:0] exp_r;
        logic [4:0]  exp_d;
        exp_r = model(opc, xop, imm, a, b);
        exp_d = (opc == 6'h24) ? fb : fc;
        @(negedge clk);
        op_code = opc; ext_code = xop; fld_b = fb; fld_c = fc;
        imm16 = imm; src_a = a; src_b = b; start = 1'b1;
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                check({req, " R2 busy after launch"}, 32'(busy), 32'd1);
            end
            if (disturb && n == 6) begin
                start = 1'b1; src_a = ~a; src_b = b + 32'd3;
                imm16 = ~imm; ext_code = 6'h07; fld_b = ~fb; fld_c = ~fc;
            end
            if (disturb && n == 7) start = 1'b0;
            if (done) break;
        end
        check({req, " R3 latency"}, 32'(n), 32'd34);
        check({req, " result"}, result, exp_r);
        check({req, " R10 dest"}, 32'(dest), 32'(exp_d));
        @(negedge clk);
        check({req, " R3 single pulse"}, 32'(done), 32'd0);
        src_a = 32'h1234_5678; src_b = 32'h0bad_f00d; fld_c = ~fc; fld_b = ~fb;
        @(negedge clk);
        @(negedge clk);
        check({req, " R4 result hold"}, result, exp_r);
        check({req, " R4 dest hold"}, 32'(dest), 32'(exp_d));
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 result", result, 0);
        check("R1 dest", 32'(dest), 0);
    endtask

    task automatic t_low();
        run_op("R5 low", 6'h3a, 6'h27, 5'd1, 5'd9, 16'h0, 32'd43, 32'd7, 0);
        run_op("R5 low neg", 6'h3a, 6'h27, 5'd2, 5'd10, 16'h0, 32'hFFFF_FFFF, 32'h8000_0000, 0);
    endtask

    task automatic t_huu();
        run_op("R6 uu max", 6'h3a, 6'h07, 5'd3, 5'd11, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R6 uu mix", 6'h3a, 6'h07, 5'd3, 5'd12, 16'h0, 32'h8000_0000, 32'h8000_0001, 0);
    endtask

    task automatic t_hsu();
        run_op("R7 su neg a", 6'h3a, 6'h17, 5'd4, 5'd13, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op("R7 su min", 6'h3a, 6'h17, 5'd4, 5'd14, 16'h0, 32'h8000_0000, 32'h7FFF_FFFF, 0);
    endtask

    task automatic t_hss();
        run_op("R8 ss min min", 6'h3a, 6'h1f, 5'd5, 5'd15, 16'h0, 32'h8000_0000, 32'h8000_0000, 0);
        run_op("R8 ss neg pos", 6'h3a, 6'h1f, 5'd5, 5'd16, 16'h0, 32'hFFFF_FFF9, 32'h0123_4567, 0);
        run_op("R8 ss zero", 6'h3a, 6'h1f, 5'd5, 5'd17, 16'h0, 32'h0, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_imm();
        run_op("R9 imm neg", 6'h24, 6'h07, 5'd21, 5'd30, 16'hFFF9, 32'd1000, 32'hFFFF_FFFF, 0);
        run_op("R9 imm min", 6'h24, 6'h1f, 5'd22, 5'd29, 16'h8000, 32'h8000_0000, 32'h5555_5555, 0);
        run_op("R9 imm pos", 6'h24, 6'h17, 5'd23, 5'd28, 16'h7FFF, 32'hFFFF_FFFF, 32'h0, 0);
    endtask

    task automatic t_default();
        run_op("R11 unknown xop", 6'h3a, 6'h33, 5'd6, 5'd18, 16'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        run_op("R11 unknown opc", 6'h05, 6'h07, 5'd7, 5'd19, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_ignore();
        run_op("R2 ignored start", 6'h3a, 6'h17, 5'd8, 5'd20, 16'h0, 32'hF000_000F, 32'h8765_4321, 1);
        run_op("R2 ignored start imm", 6'h24, 6'h27, 5'd24, 5'd3, 16'h8001, 32'h7FFF_FFFF, 32'h0, 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low();
        t_huu();
        t_hsu();
        t_hss();
        t_imm();
        t_default();
        t_ignore();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule